// File: doc/BRIEF.md
# Voltage Regulator Soft-Start Sequencer

This block produces the digital reference code for a multiphase buck controller while it starts up. Once every enable is present and power-on reset has cleared, it keeps the reference at zero for a fixed start-up delay. It then raises the reference by one 6.25 mV unit on each soft-start oscillator tick until it reaches a fixed boot level (code 176, 1.1 V). It holds that level for a fixed time and also waits for the VID input to be declared valid. After that it moves the reference one unit per tick toward the requested VID, upward or downward. A last fixed settle delay follows, and then it raises a ready request for the power-good logic.

Removing an enable, asserting power-on reset, or presenting the VID off-code while the VID is valid aborts the sequence at once. The next cycle the reference is back at zero and ready is low. Restoring the conditions starts the whole sequence again from the beginning. The phase flags show which phase is active, so that fault and monitoring logic elsewhere can pick their thresholds. Fixed delays are given in microseconds and converted to clock cycles through a clock-frequency parameter.

Top module: `vrss_softstart_seq`

## Requirements
- R1: In the cycle after any of these is seen at a clock edge, the phase is shutdown, all six phase flags are low, `ref_code` is 0 and `rdy_req` is low: `en_main` low, `en_aux` low, `por_active` high, or `vid_valid` high with `vid_code` equal to OFF_CODE (0x00). Reset gives the same state.
- R2: When the run conditions hold in shutdown, the next cycle enters the delay phase (`ph_delay`). It lasts exactly CLK_MHZ*INIT_US cycles, with `ref_code` held at 0.
- R3: In the boot ramp phase (`ph_ramp_boot`) `ref_code` rises by exactly 1 (6.25 mV) for each cycle with `ss_tick` high, until it equals BOOT_CODE (176). The cycle after it equals BOOT_CODE the hold phase begins. Ticks in any other phase leave `ref_code` unchanged.
- R4: The hold phase (`ph_boot_hold`) keeps `ref_code` at BOOT_CODE. It lasts at least CLK_MHZ*HOLD_US cycles and ends at the first cycle, from that point on, in which `vid_valid` is high.
- R5: The target is `vid_code` sampled in the last hold cycle. Its unit is 6.25 mV, so code 240 stands for 1.5 V.
- R6: In the VID ramp phase (`ph_ramp_vid`) `ref_code` moves one unit toward the target per tick, upward when the target is above the boot level and downward when it is below. The cycle after it equals the target the settle phase begins.
- R7: When the target equals BOOT_CODE, the VID ramp phase takes a single cycle and changes nothing.
- R8: The settle phase (`ph_settle`) lasts exactly CLK_MHZ*SETTLE_US cycles. It is followed by the done phase (`ph_done`), in which `rdy_req` is high and `ref_code` equals the target.
- R9: At most one phase flag is high at a time, and none is high in shutdown.
- R10: In the done phase, ticks and changes of `vid_code` to any value other than the off-code leave `ref_code` and `rdy_req` unchanged.
- R11: After an abort, restoring the run conditions repeats the full sequence from a zero reference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_main | input | 1 | Main enable, high to run |
| en_aux | input | 1 | Auxiliary rail enable, high to run |
| por_active | input | 1 | Power-on reset in progress, high to hold off |
| vid_code | input | CODE_W | Requested voltage in 6.25 mV units |
| vid_valid | input | 1 | VID code is settled and may be used |
| ss_tick | input | 1 | One-cycle pulse from the soft-start oscillator |
| ref_code | output | CODE_W | Reference code to the DAC, 6.25 mV units |
| ph_delay | output | 1 | Initial delay phase active |
| ph_ramp_boot | output | 1 | Ramp to boot level active |
| ph_boot_hold | output | 1 | Hold at boot level active |
| ph_ramp_vid | output | 1 | Ramp to VID target active |
| ph_settle | output | 1 | Settle delay before ready active |
| ph_done | output | 1 | Sequence complete |
| rdy_req | output | 1 | Ready request to the power-good logic |

## Verification
Two situations are hard to reach from the ports. One is a boot hold that is stretched because the VID becomes valid late. The other is a downward VID ramp, which only happens when a target below the boot level is valid at the moment the hold ends. The stimulus keeps `vid_valid` low until well after the boot level is reached, and it restarts the sequence with a target of code 160 already valid. Aborts are placed in the delay phase, in the middle of the boot ramp and in the done phase. The tick spacing changes between runs so that ramps at one tick per cycle are also covered.

// File: rtl/vrss_pkg.sv
package vrss_pkg;
   typedef enum logic [2:0] {
      PH_OFF    = 3'd0,
      PH_DELAY  = 3'd1,
      PH_RAMP1  = 3'd2,
      PH_BOOT   = 3'd3,
      PH_RAMP2  = 3'd4,
      PH_SETTLE = 3'd5,
      PH_DONE   = 3'd6
   } vrss_phase_e;
endpackage

// File: rtl/vrss_cycle_timer.sv
module vrss_cycle_timer #(
   parameter int LIMIT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic expired
);
   localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

   if (LIMIT < 1) begin : g_bad
      $error("vrss_cycle_timer: LIMIT must be at least 1");
   end

   if (LIMIT <= 1) begin : g_trivial
      assign expired = run;
   end else begin : g_count
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cnt_q <= '0;
         else if (!run)
            cnt_q <= '0;
         else if (cnt_q != CW'(LIMIT - 1))
            cnt_q <= cnt_q + 1'b1;
      end
      assign expired = run && (cnt_q == CW'(LIMIT - 1));

      // R2
      no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (run && expired) |=> (!run || expired));
   end
endmodule

// File: rtl/vrss_ramp.sv
module vrss_ramp #(
   parameter int CODE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              active,
   input  logic              tick,
   input  logic [CODE_W-1:0] goal,
   output logic [CODE_W-1:0] code,
   output logic              at_goal
);
   logic [CODE_W-1:0] code_q;

   assign at_goal = (code_q == goal);
   assign code    = code_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         code_q <= '0;
      else if (clr)
         code_q <= '0;
      else if (active && tick && !at_goal) begin
         if (code_q < goal)
            code_q <= code_q + 1'b1;
         else
            code_q <= code_q - 1'b1;
      end
   end

   // R3
   one_unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(clr) && (code_q != $past(code_q))) |->
      ($past(tick && active) &&
       ((code_q == $past(code_q) + 1'b1) || (code_q == $past(code_q) - 1'b1))));

   // R6
   no_overshoot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && active && at_goal) |=> $stable(code_q));
endmodule

// File: rtl/vrss_softstart_seq.sv
module vrss_softstart_seq
   import vrss_pkg::*;
#(
   parameter int CODE_W    = 8,
   parameter int BOOT_CODE = 176,
   parameter int OFF_CODE  = 0,
   parameter int CLK_MHZ   = 200,
   parameter int INIT_US   = 1360,
   parameter int HOLD_US   = 85,
   parameter int SETTLE_US = 85
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_main,
   input  logic              en_aux,
   input  logic              por_active,
   input  logic [CODE_W-1:0] vid_code,
   input  logic              vid_valid,
   input  logic              ss_tick,
   output logic [CODE_W-1:0] ref_code,
   output logic              ph_delay,
   output logic              ph_ramp_boot,
   output logic              ph_boot_hold,
   output logic              ph_ramp_vid,
   output logic              ph_settle,
   output logic              ph_done,
   output logic              rdy_req
);
   localparam int INIT_CYC   = CLK_MHZ * INIT_US;
   localparam int HOLD_CYC   = CLK_MHZ * HOLD_US;
   localparam int SETTLE_CYC = CLK_MHZ * SETTLE_US;
   localparam logic [CODE_W-1:0] BOOT_LVL = CODE_W'(BOOT_CODE);
   localparam logic [CODE_W-1:0] OFF_LVL  = CODE_W'(OFF_CODE);

   if (CODE_W < 2) begin : g_chk_w
      $error("vrss_softstart_seq: CODE_W too small");
   end
   if (BOOT_CODE < 1 || BOOT_CODE >= (1 << CODE_W)) begin : g_chk_boot
      $error("vrss_softstart_seq: BOOT_CODE out of range");
   end
   if (OFF_CODE < 0 || OFF_CODE >= (1 << CODE_W)) begin : g_chk_off
      $error("vrss_softstart_seq: OFF_CODE out of range");
   end
   if (CLK_MHZ < 1 || INIT_US < 1 || HOLD_US < 1 || SETTLE_US < 1) begin : g_chk_t
      $error("vrss_softstart_seq: timing parameters must be positive");
   end

   vrss_phase_e       phase_q, phase_d;
   logic [CODE_W-1:0] tgt_q;
   logic              run;
   logic              init_exp, hold_exp, settle_exp;
   logic              ramp_clr, ramp_act, ramp_at;
   logic [CODE_W-1:0] ramp_goal;

   assign run = en_main && en_aux && !por_active &&
                !(vid_valid && (vid_code == OFF_LVL));

   vrss_cycle_timer #(.LIMIT(INIT_CYC)) u_init_tmr (
      .clk(clk), .rst_n(rst_n), .run(phase_q == PH_DELAY), .expired(init_exp));
   vrss_cycle_timer #(.LIMIT(HOLD_CYC)) u_hold_tmr (
      .clk(clk), .rst_n(rst_n), .run(phase_q == PH_BOOT), .expired(hold_exp));
   vrss_cycle_timer #(.LIMIT(SETTLE_CYC)) u_settle_tmr (
      .clk(clk), .rst_n(rst_n), .run(phase_q == PH_SETTLE), .expired(settle_exp));

   assign ramp_clr  = !run || (phase_q == PH_OFF);
   assign ramp_act  = (phase_q == PH_RAMP1) || (phase_q == PH_RAMP2);
   assign ramp_goal = (phase_q == PH_RAMP1) ? BOOT_LVL : tgt_q;

   vrss_ramp #(.CODE_W(CODE_W)) u_ramp (
      .clk(clk), .rst_n(rst_n), .clr(ramp_clr), .active(ramp_act),
      .tick(ss_tick), .goal(ramp_goal), .code(ref_code), .at_goal(ramp_at));

   always_comb begin
      phase_d = phase_q;
      if (!run)
         phase_d = PH_OFF;
      else begin
         case (phase_q)
            PH_OFF:    phase_d = PH_DELAY;
            PH_DELAY:  if (init_exp) phase_d = PH_RAMP1;
            PH_RAMP1:  if (ramp_at) phase_d = PH_BOOT;
            PH_BOOT:   if (hold_exp && vid_valid) phase_d = PH_RAMP2;
            PH_RAMP2:  if (ramp_at) phase_d = PH_SETTLE;
            PH_SETTLE: if (settle_exp) phase_d = PH_DONE;
            PH_DONE:   phase_d = PH_DONE;
            default:   phase_d = PH_OFF;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_OFF;
         tgt_q   <= '0;
      end else begin
         phase_q <= phase_d;
         if (phase_q == PH_BOOT && phase_d == PH_RAMP2)
            tgt_q <= vid_code;
      end
   end

   assign ph_delay     = (phase_q == PH_DELAY);
   assign ph_ramp_boot = (phase_q == PH_RAMP1);
   assign ph_boot_hold = (phase_q == PH_BOOT);
   assign ph_ramp_vid  = (phase_q == PH_RAMP2);
   assign ph_settle    = (phase_q == PH_SETTLE);
   assign ph_done      = (phase_q == PH_DONE);
   assign rdy_req      = ph_done;

   // R1
   abort_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (phase_q == PH_OFF && ref_code == '0 && !rdy_req));

   // R9
   flags_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ph_delay, ph_ramp_boot, ph_boot_hold, ph_ramp_vid, ph_settle, ph_done}));

   // R2
   delay_zero_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ph_delay |-> (ref_code == '0));

   // R4
   hold_at_boot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ph_boot_hold |-> (ref_code == BOOT_LVL));

   // R8
   ready_on_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rdy_req |-> (ref_code == tgt_q));

   // R10
   done_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_done && run) |=> $stable(ref_code));
endmodule

// File: tb/sim_vrss_softstart_seq.sv
module sim_vrss_softstart_seq;
   localparam int CW = 8;
   localparam int BOOT = 176;
   localparam int INIT_N = 20;
   localparam int HOLD_N = 8;
   localparam int SETL_N = 6;
   localparam int WDOG = 150000;

   logic clk = 1'b0;
   logic rst_n;
   logic en_main, en_aux, por_active, vid_valid, ss_tick;
   logic [CW-1:0] vid_code;
   logic [CW-1:0] ref_code;
   logic ph_delay, ph_ramp_boot, ph_boot_hold, ph_ramp_vid, ph_settle, ph_done, rdy_req;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   bit cmp_on = 1'b0;
   bit tick_en = 1'b0;
   int tick_div = 3;
   int tick_ctr = 0;

   // reference model state
   int m_ph = 0;   // 0 off,1 delay,2 ramp boot,3 hold,4 ramp vid,5 settle,6 done
   int m_code = 0;
   int m_tgt = 0;
   int m_age = 0;

   always #2.5 clk = ~clk;

   vrss_softstart_seq #(.CODE_W(CW), .BOOT_CODE(BOOT), .OFF_CODE(0), .CLK_MHZ(1),
      .INIT_US(INIT_N), .HOLD_US(HOLD_N), .SETTLE_US(SETL_N)) u0 (
      .clk(clk), .rst_n(rst_n), .en_main(en_main), .en_aux(en_aux),
      .por_active(por_active), .vid_code(vid_code), .vid_valid(vid_valid),
      .ss_tick(ss_tick), .ref_code(ref_code), .ph_delay(ph_delay),
      .ph_ramp_boot(ph_ramp_boot), .ph_boot_hold(ph_boot_hold),
      .ph_ramp_vid(ph_ramp_vid), .ph_settle(ph_settle), .ph_done(ph_done),
      .rdy_req(rdy_req));

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
      end
   endtask

   function automatic string ph_tag(input int p);
      case (p)
         1: return "R2";
         2: return "R3";
         3: return "R4";
         4: return "R6";
         5: return "R8";
         6: return "R10";
         default: return "R1";
      endcase
   endfunction

   // soft-start oscillator tick
   always @(negedge clk) begin
      if (tick_en) begin
         tick_ctr++;
         if (tick_ctr >= tick_div) begin
            ss_tick = 1'b1;
            tick_ctr = 0;
         end else
            ss_tick = 1'b0;
      end else
         ss_tick = 1'b0;
   end

   // behavioural reference model
   always @(posedge clk or negedge rst_n) begin
      int nph;
      bit go;
      if (!rst_n) begin
         m_ph = 0; m_code = 0; m_tgt = 0; m_age = 0;
      end else begin
         go = en_main && en_aux && !por_active && !(vid_valid && vid_code == 0);
         nph = m_ph;
         if (!go) begin
            nph = 0;
            m_code = 0;
         end else begin
            case (m_ph)
               0: nph = 1;
               1: if (m_age == INIT_N - 1) nph = 2;
               2: if (m_code == BOOT) nph = 3;
                  else if (ss_tick) m_code = m_code + 1;
               3: if (m_age >= HOLD_N - 1 && vid_valid) begin
                     nph = 4;
                     m_tgt = int'(vid_code);
                  end
               4: if (m_code == m_tgt) nph = 5;
                  else if (ss_tick) m_code = (m_code < m_tgt) ? m_code + 1 : m_code - 1;
               5: if (m_age == SETL_N - 1) nph = 6;
               default: ;
            endcase
         end
         m_age = (nph != m_ph) ? 0 : m_age + 1;
         m_ph = nph;
      end
   end

   // per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      int fl, efl;
      cyc++;
      if (cmp_on) begin
         fl = {26'd0, ph_done, ph_settle, ph_ramp_vid, ph_boot_hold, ph_ramp_boot, ph_delay};
         efl = (m_ph == 0) ? 0 : (1 << (m_ph - 1));
         check(int'(ref_code) == m_code, ph_tag(m_ph), int'(ref_code), m_code);
         check(fl == efl, "R9", fl, efl);
         check(int'(rdy_req) == int'(m_ph == 6), "R8", int'(rdy_req), int'(m_ph == 6));
      end
      if (cyc >= WDOG) begin
         total++;
         bad++;
         $display("FAIL R11 watchdog actual=%0d expected<%0d", cyc, WDOG);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_rdy(input int max);
      for (int i = 0; i < max && !rdy_req; i++) @(negedge clk);
   endtask

   task automatic wait_hold(input int max);
      for (int i = 0; i < max && !ph_boot_hold; i++) @(negedge clk);
   endtask

   initial begin
      en_main = 1'b0; en_aux = 1'b0; por_active = 1'b1;
      vid_code = '0; vid_valid = 1'b0; ss_tick = 1'b0;
      rst_n = 1'b0;
      step(3);
      rst_n = 1'b1;
      step(1);
      cmp_on = 1'b1;
      // R1 reset state
      check(ref_code == 0 && !rdy_req && !ph_delay, "R1", int'(ref_code), 0);
      tick_en = 1'b1;

      // late VID: stretched hold, ramp up to 240 (1.5 V)
      por_active = 1'b0; en_main = 1'b1; en_aux = 1'b1;
      step(2);
      check(ph_delay == 1'b1, "R2", int'(ph_delay), 1);
      wait_hold(2000);
      check(int'(ref_code) == BOOT, "R3", int'(ref_code), BOOT);
      step(30);
      check(ph_boot_hold == 1'b1, "R4", int'(ph_boot_hold), 1);
      vid_code = 8'd240; vid_valid = 1'b1;
      wait_rdy(3000);
      check(int'(ref_code) == 240, "R5", int'(ref_code), 240);
      step(20);
      vid_code = 8'd200;
      step(20);
      check(int'(ref_code) == 240 && rdy_req, "R10", int'(ref_code), 240);

      // abort by auxiliary enable, restart with a lower target
      en_aux = 1'b0;
      step(1);
      check(ref_code == 0 && !rdy_req, "R1", int'(ref_code), 0);
      tick_div = 1;
      vid_code = 8'd160;
      en_aux = 1'b1;
      wait_rdy(3000);
      check(int'(ref_code) == 160, "R6", int'(ref_code), 160);
      check(rdy_req == 1'b1, "R11", int'(rdy_req), 1);

      // abort by power-on reset in the middle of the boot ramp
      tick_div = 2;
      por_active = 1'b1;
      step(1);
      por_active = 1'b0;
      step(80);
      check(ph_ramp_boot == 1'b1, "R3", int'(ph_ramp_boot), 1);
      por_active = 1'b1;
      step(1);
      check(ref_code == 0 && !ph_ramp_boot, "R1", int'(ref_code), 0);
      por_active = 1'b0;
      vid_code = 8'd176;
      wait_rdy(3000);
      check(int'(ref_code) == BOOT, "R7", int'(ref_code), BOOT);

      // off-code abort in the done phase
      vid_code = 8'd0;
      step(1);
      check(!rdy_req && ref_code == 0, "R1", int'(rdy_req), 0);

      // enable dropped during the delay, then full restart
      tick_div = 3;
      vid_code = 8'd250;
      step(10);
      en_main = 1'b0;
      step(1);
      check(!ph_delay && ref_code == 0, "R1", int'(ph_delay), 0);
      en_main = 1'b1;
      wait_rdy(3000);
      check(int'(ref_code) == 250 && rdy_req, "R11", int'(ref_code), 250);

      step(5);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule